// File: doc/BRIEF.md
# Three-Level Input Watchdog Timer

This block supervises a processor's heartbeat line. The line has three states: driven high, driven low, or left open. An analog front end outside the block reduces it to two digital inputs: a level and a flag that says the line is open. While the line is driven, every change of level counts as proof that the processor is alive and restarts the timeout. If the level stays unchanged for the whole timeout, the block sends a single-cycle trip strobe to the reset generator.

An open line turns the watchdog off. The reset generator's own active-reset signal and the supply monitor's battery-backup indication each hold the timer at zero for as long as they are asserted. Counting starts again from zero once all three holds are gone. The timeout is set in milliseconds and derived from the clock frequency. Its value is clamped to the allowed window. Both the level and the open flag pass through a two-flop synchronizer. To catch a 50 ns pulse, the clock period must be 50 ns or shorter (20 MHz or faster).

Top module: `wdog_tri_monitor`

## Requirements
- R1: With the line driven at a constant level and no hold asserted, `trip` rises exactly TICKS clock edges after the last edge at which the counter was cleared. The counter restarts from zero on the edge that raises `trip`.
- R2: `trip` is high for exactly one clock cycle per timeout.
- R3: A change of `wd_level` clears the counter. A level change applied before edge M clears the counter at edge M+2, after two synchronizer stages and one history flop. The next trip then follows TICKS edges later.
- R4: A level pulse that is sampled by a single clock edge counts as activity and restarts the timeout.
- R5: While `wd_open` is 1, the counter is held at zero and no trip occurs. The flag goes through the same two-stage synchronizer as the level. Its synchronizer resets to the open state.
- R6: While `rst_active` is 1, the counter stays at zero for the whole time, not only at the start. Counting resumes from zero after `rst_active` returns to 0.
- R7: While `backup_mode` is 1, the watchdog is disabled and held at zero in the same way.
- R8: TICKS = CLK_HZ × ms / 1000, where ms is TIMEOUT_MS clamped to the window 1000 to 2250.
- R9: While `rst_n` is 0, `trip` is 0, the counter is zero and the line is treated as open.
- R10: If the reset generator answers each trip by holding `rst_active` high for S cycles, and the line stays at a constant level, trips recur every TICKS + S cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; period of 50 ns or less for minimum-pulse capture |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_level | input | 1 | Level of the heartbeat line from the front end |
| wd_open | input | 1 | 1 when the heartbeat line is undriven (floating) |
| rst_active | input | 1 | 1 while the system reset output is asserted |
| backup_mode | input | 1 | 1 while the supply runs from the backup battery |
| trip | output | 1 | One-cycle timeout strobe to the reset generator |

## Verification
The hardest case to reach from the ports is a level pulse that exactly one clock edge sees, arriving in the middle of an otherwise expiring count. The bench drives the level for one full cycle between two falling edges, 20 cycles into a 32-cycle count. It then requires the trip to move out to the cycle computed from the clear that the pulse's falling edge causes. Periodic tripping is checked by a model of the reset generator in the bench, which stretches `rst_active` after every trip. The clamping of the timeout is checked by two further instances whose requested timeouts lie outside the window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam longint unsigned MS_MIN = 1000;
  localparam longint unsigned MS_MAX = 2250;

  // R8: requested timeout forced into the allowed window
  function automatic longint unsigned clamp_ms(longint unsigned ms);
    if (ms < MS_MIN) return MS_MIN;
    if (ms > MS_MAX) return MS_MAX;
    return ms;
  endfunction

  // R8: number of clock ticks in one timeout
  function automatic longint unsigned timeout_ticks(longint unsigned hz,
                                                    longint unsigned ms);
    return (hz * clamp_ms(ms)) / 1000;
  endfunction

  // width of a counter holding 0 .. ticks-1
  function automatic int count_width(longint unsigned ticks);
    return (ticks < 3) ? 1 : $clog2(ticks);
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_s,
  output logic activity
);
  logic lvl_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl_s;
  end

  // R3, R4: one sample of difference is enough to flag activity
  assign activity = lvl_s ^ lvl_prev;

  // R4
  // a change seen by the history flop must have been flagged one cycle earlier
  prev_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> (lvl_prev == $past(lvl_s)));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter longint unsigned TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic activity,
  output logic trip
);
  localparam int CW = wdt_pkg::count_width(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          expire;
  logic          clear;

  assign expire = !hold && !activity && (cnt == LAST);
  assign clear  = hold | activity | expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      trip <= 1'b0;
    end else begin
      cnt  <= clear ? '0 : cnt + 1'b1;
      trip <= expire;
    end
  end

  // R2
  trip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !trip);

  // R6
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

  // R3
  act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> (cnt == '0));

  // R1
  trip_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> ($past(cnt) == LAST && cnt == '0));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/wdog_tri_monitor.sv
module wdog_tri_monitor #(
  parameter int unsigned CLK_HZ      = 20_000_000,
  parameter int unsigned TIMEOUT_MS  = 1600,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_level,
  input  logic wd_open,
  input  logic rst_active,
  input  logic backup_mode,
  output logic trip
);
  localparam longint unsigned TICKS =
    wdt_pkg::timeout_ticks(longint'(CLK_HZ), longint'(TIMEOUT_MS));

  logic lvl_s;
  logic open_s;
  logic activity;
  logic hold;

  wdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lvl (
    .clk(clk), .rst_n(rst_n), .din(wd_level), .dout(lvl_s));

  // R9: reset value marks the line as open
  wdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_open (
    .clk(clk), .rst_n(rst_n), .din(wd_open), .dout(open_s));

  wdt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_s(lvl_s), .activity(activity));

  // R5, R6, R7
  assign hold = open_s | rst_active | backup_mode;

  wdt_timer #(.TICKS(TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(hold), .activity(activity), .trip(trip));

  // R6, R7
  hold_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_active || backup_mode) |=> !trip);
endmodule

// File: tb/sim_wdog_tri_monitor.sv
module sim_wdog_tri_monitor;
  localparam int CLK_NS  = 10;
  localparam int L       = 32;   // 20 Hz x 1600 ms
  localparam int STRETCH = 4;
  localparam int L_HI    = 45;   // 3000 ms clamped to 2250
  localparam int L_LO    = 20;   // 400 ms clamped to 1000

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_level = 1'b0;
  logic wd_open = 1'b1;
  logic hold_rst = 1'b0;
  logic stretch_rst = 1'b0;
  logic backup_mode = 1'b0;
  logic rst_active;
  logic trip;
  logic open_aux = 1'b1;
  logic trip_hi, trip_lo;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int stretch_left = 0;
  int hi_first = -1;
  int lo_first = -1;
  string cur_req = "R9";
  bit done = 1'b0;

  assign rst_active = hold_rst | stretch_rst;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_tri_monitor #(.CLK_HZ(20), .TIMEOUT_MS(1600)) u0 (
    .clk(clk), .rst_n(rst_n), .wd_level(wd_level), .wd_open(wd_open),
    .rst_active(rst_active), .backup_mode(backup_mode), .trip(trip));

  wdog_tri_monitor #(.CLK_HZ(20), .TIMEOUT_MS(3000)) u_hi (
    .clk(clk), .rst_n(rst_n), .wd_level(1'b0), .wd_open(open_aux),
    .rst_active(1'b0), .backup_mode(1'b0), .trip(trip_hi));

  wdog_tri_monitor #(.CLK_HZ(20), .TIMEOUT_MS(400)) u_lo (
    .clk(clk), .rst_n(rst_n), .wd_level(1'b0), .wd_open(open_aux),
    .rst_active(1'b0), .backup_mode(1'b0), .trip(trip_lo));

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: scoreboard pop, plus reset-generator model (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (stretch_left > 0) begin
        stretch_left--;
        if (stretch_left == 0) stretch_rst = 1'b0;
      end
      if (trip) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected trip at cycle", cyc, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, cur_req, "trip cycle", cyc, e);
        end
        stretch_rst = 1'b1;
        stretch_left = STRETCH;
      end
      if (trip_hi && hi_first < 0) hi_first = cyc;
      if (trip_lo && lo_first < 0) lo_first = cyc;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    chk(1'b0, "watchdog", "run did not finish, cycle", cyc, 0);
    finish_run();
  end

  initial begin
    int n, t1, t2, t3, m, c;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(trip == 1'b0, "R9", "trip during reset", trip, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(trip == 1'b0, "R9", "trip after reset", trip, 0);

    // R5: open line, long wait, no trip
    cur_req = "R5";
    repeat (3 * L) @(negedge clk);
    chk(trip == 1'b0, "R5", "trip while open", trip, 0);

    // R1, R2, R10: constant level, reset stretch model answers every trip
    cur_req = "R10";
    n = cyc;
    wd_open = 1'b0;
    t1 = n + 2 + L;
    t2 = t1 + STRETCH + L;
    t3 = t2 + STRETCH + L;
    exp_q.push_back(t1);
    exp_q.push_back(t2);
    exp_q.push_back(t3);
    wait_cyc(t1);
    chk(trip == 1'b1, "R1", "trip at first timeout", trip, 1);
    @(negedge clk);
    chk(trip == 1'b0, "R2", "trip one cycle later", trip, 0);
    wait_cyc(t3 + 1);
    wd_open = 1'b1;
    repeat (2 * L) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "pending trips", exp_q.size(), 0);

    // R3: toggles faster than the timeout keep it from expiring
    cur_req = "R3";
    wd_open = 1'b0;
    for (int i = 0; i < 20; i++) begin
      repeat (10) @(negedge clk);
      wd_level = ~wd_level;
    end
    m = cyc;
    exp_q.push_back(m + 3 + L);
    wait_cyc(m + 3 + L + 1);
    wd_open = 1'b1;
    repeat (2 * L) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "pending trips", exp_q.size(), 0);

    // R4: single-sample pulse mid-count restarts the timeout
    cur_req = "R4";
    n = cyc;
    wd_open = 1'b0;
    c = n + 2;
    exp_q.push_back(c + 24 + L);
    wait_cyc(c + 20);
    wd_level = ~wd_level;
    @(negedge clk);
    wd_level = ~wd_level;
    wait_cyc(c + L + 1);
    chk(trip == 1'b0, "R4", "no trip at unpulsed deadline", trip, 0);
    wait_cyc(c + 24 + L + 1);
    wd_open = 1'b1;
    repeat (2 * L) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "pending trips", exp_q.size(), 0);

    // R6: reset held far longer than the timeout
    cur_req = "R6";
    hold_rst = 1'b1;
    wd_open = 1'b0;
    repeat (3 * L) @(negedge clk);
    chk(trip == 1'b0, "R6", "trip while reset held", trip, 0);
    n = cyc;
    hold_rst = 1'b0;
    exp_q.push_back(n + L);
    wait_cyc(n + L + 1);
    wd_open = 1'b1;
    repeat (2 * L) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "pending trips", exp_q.size(), 0);

    // R7: backup mode held far longer than the timeout
    cur_req = "R7";
    backup_mode = 1'b1;
    wd_open = 1'b0;
    repeat (3 * L) @(negedge clk);
    chk(trip == 1'b0, "R7", "trip in backup mode", trip, 0);
    n = cyc;
    backup_mode = 1'b0;
    exp_q.push_back(n + L);
    wait_cyc(n + L + 1);
    wd_open = 1'b1;
    repeat (2 * L) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "pending trips", exp_q.size(), 0);

    // R8: clamping of out-of-window timeouts
    cur_req = "R8";
    n = cyc;
    open_aux = 1'b0;
    wait_cyc(n + 2 + L_HI + 1);
    open_aux = 1'b1;
    chk(lo_first == n + 2 + L_LO, "R8", "low clamp trip cycle", lo_first, n + 2 + L_LO);
    chk(hi_first == n + 2 + L_HI, "R8", "high clamp trip cycle", hi_first, n + 2 + L_HI);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule